// File: doc/BRIEF.md
# ADC Serial Result Port

This block is the device-side logic behind the serial result output of a 12-bit sampling converter. A host starts a conversion by driving the active-low select line and the read/convert line LOW together. The block then holds `busy` LOW for a modelled conversion time. Inside that window it copies the conversion result into an output register. The analog front end is not modelled: the result is taken from the `sample_val` input at the start of the conversion.

The serial line `sdo` is fed by one of two clock sources, chosen by the static `ext_mode` input:

- **Internal clock (`ext_mode` LOW).** Each start also launches a burst of exactly twelve pulses on `sclk_out`, made by dividing the system clock. The burst carries the result of the previous conversion, MSB first. Each bit changes in the middle of the clock's low phase, so the host may sample on either edge. Once the burst ends, `sdo` shows a tag bit, which lets devices be chained.
- **External clock (`ext_mode` HIGH).** The host supplies `ext_sclk`. The block synchronises it, and each rising edge shifts the newest result while the read window is open. `tag_in` enters at the far end of the shift register.

One timing hazard is modelled. If the read window is open and the host clock is HIGH at the moment the output register is loaded, the new result is dropped.

Top module: `adc_serial_port`

## Requirements
- R1: A conversion starts on the cycle where `sel_n`=0 and `rdconv`=0 first hold together while no conversion runs. `busy` goes LOW on the next cycle, stays LOW for exactly CONV_CYCLES cycles, then returns HIGH. A new request made while `busy` is LOW is ignored and does not lengthen the conversion.
- R2: With `ext_mode`=0, each conversion produces exactly 12 pulses on `sclk_out`. Each pulse is 2·SCLK_QTR cycles LOW followed by 2·SCLK_QTR cycles HIGH, and the burst begins at the start of the conversion.
- R3: The 12 bits sent in the internal burst are the result of the previous conversion, MSB first, with the first bit on `sdo` from the start of the burst.
- R4: `sdo` never changes on the same cycle as a rising or falling transition of `sclk_out`.
- R5: After the 12th internal pulse, `sclk_out` stays LOW until the next start, and the burst is complete before `busy` rises. `sdo` then holds the `tag_in` level sampled at the first rising edge of `sclk_out`.
- R6: With `ext_mode`=1, `sclk_out` stays LOW. The new result is loaded LOAD_AT+1 cycles after the start, and its MSB then appears on `sdo`.
- R7: With `ext_mode`=1, every synchronised rising edge of `ext_sclk` seen while `sel_n`=0 and `rdconv`=1 shifts the register one place toward the MSB, filling from `tag_in`. After 12 such edges, `sdo` shows the `tag_in` level of the first edge. Edges seen while `sel_n`=1 shift nothing.
- R8: If `ext_mode`=1, `sel_n`=0, `rdconv`=1 and the synchronised `ext_sclk` is HIGH at the load cycle, the new result is discarded. The output register and the `sdo` shift state keep their previous contents.
- R9: After reset: `busy`=1, `sclk_out`=0, `sdo`=0, and the stored previous result is 0.
- R10: `sdo` is always driven to 0 or 1 and is never left undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| rdconv | input | 1 | LOW requests a conversion, HIGH opens the read window |
| ext_mode | input | 1 | Static clock source: 1 = host clock, 0 = internal burst |
| ext_sclk | input | 1 | Host data clock, asynchronous |
| tag_in | input | 1 | Chain bit shifted in behind the result |
| sample_val | input | RES_W | Modelled conversion result, taken at start |
| busy | output | 1 | LOW while a conversion runs |
| sclk_out | output | 1 | Internal data clock output |
| sdo | output | 1 | Serial result data, always driven |

## Verification
The hardest situation to reach is the load hazard. It needs the synchronised host clock to be HIGH with the read window open at one cycle deep inside the conversion, and it must be reached without a rising edge being counted as a shift. The bench raises `ext_sclk` while `sel_n` is HIGH, so that edge shifts nothing. It then starts the conversion and opens the read window with the clock still HIGH, and lowers the clock only after `busy` has returned. The bench shows that the result was lost in two ways: `sdo` is unchanged, and the next conversion, switched to internal mode, replays the retained older result as its previous-result burst.

// File: rtl/adc_sp_pkg.sv
`timescale 1ns/1ps
package adc_sp_pkg;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic start;
        logic load;
        logic done;
    } conv_evt_t;

    typedef struct packed {
        logic active;
        logic sclk;
        logic shift;
        logic tag_cap;
    } burst_ctl_t;

    function automatic logic start_cond(input logic sel_n, input logic rdconv);
        return !sel_n && !rdconv;
    endfunction

    function automatic logic read_window(input logic sel_n, input logic rdconv);
        return !sel_n && rdconv;
    endfunction

    function automatic logic load_blocked(input clk_src_e src, input logic sel_n,
                                          input logic rdconv, input logic ext_hi);
        return (src == SRC_EXTERNAL) && read_window(sel_n, rdconv) && ext_hi;
    endfunction

endpackage

// File: rtl/adc_sp_sync.sv
`timescale 1ns/1ps
module adc_sp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] && !last_q;
endmodule

// File: rtl/adc_sp_conv.sv
`timescale 1ns/1ps
module adc_sp_conv
    import adc_sp_pkg::*;
#(
    parameter int CONV_CYCLES = 128,
    parameter int LOAD_AT     = 110
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_n,
    input  logic      rdconv,
    output conv_evt_t evt,
    output logic      busy
);
    localparam int CNT_W = $clog2(CONV_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_IDX = CNT_W'(LOAD_AT);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CONV_CYCLES - 1);

    logic             req;
    logic             req_q;
    logic             active_q;
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    assign req = start_cond(sel_n, rdconv);

    always_comb begin
        evt.start = req && !req_q && !active_q;
        evt.load  = active_q && (cnt_q == LOAD_IDX);
        evt.done  = active_q && (cnt_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= 1'b0;
            active_q <= 1'b0;
            busy_q   <= 1'b1;
            cnt_q    <= '0;
        end else begin
            req_q <= req;
            if (evt.start) begin
                active_q <= 1'b1;
                busy_q   <= 1'b0;
                cnt_q    <= '0;
            end else if (active_q) begin
                if (evt.done) begin
                    active_q <= 1'b0;
                    busy_q   <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/adc_sp_burst.sv
`timescale 1ns/1ps
module adc_sp_burst
    import adc_sp_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int QTR   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output burst_ctl_t ctl
);
    localparam int DIV  = 4 * QTR;
    localparam int PH_W = $clog2(DIV);
    localparam int PC_W = $clog2(RES_W + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_MOVE = PH_W'(QTR);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(2 * QTR);
    localparam logic [PC_W-1:0] PC_END  = PC_W'(RES_W);

    logic            run_q;
    logic [PH_W-1:0] ph_q;
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            pc_q  <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            ph_q  <= '0;
            pc_q  <= '0;
        end else if (run_q) begin
            if (pc_q == PC_END && ph_q == PH_MOVE) begin
                run_q <= 1'b0;
            end
            if (ph_q == PH_LAST) begin
                ph_q <= '0;
                pc_q <= pc_q + 1'b1;
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    always_comb begin
        ctl.active  = run_q;
        ctl.sclk    = run_q && (pc_q != PC_END) && (ph_q >= PH_HIGH);
        ctl.shift   = run_q && (pc_q != '0) && (ph_q == PH_MOVE);
        ctl.tag_cap = run_q && (pc_q == '0) && (ph_q == PH_HIGH);
    end
endmodule

// File: rtl/adc_serial_port.sv
`timescale 1ns/1ps
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 128,
    parameter int LOAD_AT     = 110,
    parameter int SCLK_QTR    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n,
    input  logic             rdconv,
    input  logic             ext_mode,
    input  logic             ext_sclk,
    input  logic             tag_in,
    input  logic [RES_W-1:0] sample_val,
    output logic             busy,
    output logic             sclk_out,
    output logic             sdo
);
    clk_src_e   src;
    conv_evt_t  evt;
    burst_ctl_t bctl;
    logic       ext_hi;
    logic       ext_rise;
    logic       burst_start;
    logic       read_en;
    logic       blocked;

    logic [RES_W-1:0] samp_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] shreg_q;
    logic             tag_q;

    assign src = clk_src_e'(ext_mode);

    adc_sp_conv #(
        .CONV_CYCLES(CONV_CYCLES),
        .LOAD_AT    (LOAD_AT)
    ) conv_i (
        .clk   (clk),
        .rst   (rst),
        .sel_n (sel_n),
        .rdconv(rdconv),
        .evt   (evt),
        .busy  (busy)
    );

    adc_sp_sync #(
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_in(ext_sclk),
        .level   (ext_hi),
        .rise    (ext_rise)
    );

    assign burst_start = evt.start && (src == SRC_INTERNAL);

    adc_sp_burst #(
        .RES_W(RES_W),
        .QTR  (SCLK_QTR)
    ) burst_i (
        .clk  (clk),
        .rst  (rst),
        .start(burst_start),
        .ctl  (bctl)
    );

    assign read_en = read_window(sel_n, rdconv);
    assign blocked = load_blocked(src, sel_n, rdconv, ext_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q  <= '0;
            res_q   <= '0;
            shreg_q <= '0;
            tag_q   <= 1'b0;
        end else begin
            if (evt.start) begin
                samp_q <= sample_val;
            end
            if (bctl.tag_cap) begin
                tag_q <= tag_in;
            end
            if (evt.load && !blocked) begin
                res_q <= samp_q;
            end
            if (burst_start) begin
                shreg_q <= res_q;
            end else if (bctl.shift) begin
                shreg_q <= {shreg_q[RES_W-2:0], tag_q};
            end else if (src == SRC_EXTERNAL && read_en && ext_rise) begin
                shreg_q <= {shreg_q[RES_W-2:0], tag_in};
            end else if (src == SRC_EXTERNAL && evt.load && !blocked) begin
                shreg_q <= samp_q;
            end
        end
    end

    assign sclk_out = bctl.sclk && (src == SRC_INTERNAL);
    assign sdo      = shreg_q[RES_W-1];
endmodule

// File: rtl/adc_sp_checker.sv
`timescale 1ns/1ps
module adc_sp_checker #(
    parameter int RES_W       = 12,
    parameter int CONV_CYCLES = 128
) (
    input logic clk,
    input logic rst,
    input logic ext_mode,
    input logic busy,
    input logic sclk_out,
    input logic sdo
);
    localparam int LOW_W = $clog2(CONV_CYCLES + 1) + 1;
    localparam int P_W   = $clog2(RES_W + 1) + 1;

    logic [LOW_W-1:0] low_cnt;
    logic [P_W-1:0]   pulse_cnt;
    logic             busy_q;
    logic             sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            pulse_cnt <= '0;
            busy_q    <= 1'b1;
            sclk_q    <= 1'b0;
        end else begin
            busy_q  <= busy;
            sclk_q  <= sclk_out;
            low_cnt <= busy ? '0 : low_cnt + 1'b1;
            if (busy_q && !busy) begin
                pulse_cnt <= '0;
            end else if (sclk_out && !sclk_q) begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> low_cnt == LOW_W'(CONV_CYCLES)); // R1

    AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && $rose(busy)) |-> pulse_cnt == P_W'(RES_W)); // R2

    AST_SDO_HOLD_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (sclk_out != $past(sclk_out)) |-> $stable(sdo)); // R4

    AST_CLOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sclk_out); // R5

    AST_EXT_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
        ext_mode |-> !sclk_out); // R6

    AST_SDO_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        (sdo == 1'b0) || (sdo == 1'b1)); // R10
endmodule

bind adc_serial_port adc_sp_checker #(
    .RES_W      (RES_W),
    .CONV_CYCLES(CONV_CYCLES)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .ext_mode(ext_mode),
    .busy    (busy),
    .sclk_out(sclk_out),
    .sdo     (sdo)
);

// File: tb/adc_serial_port_tb.sv
`timescale 1ns/1ps
module adc_serial_port_tb_top;
    localparam int W    = 12;
    localparam int CONV = 128;
    localparam int LOAD = 110;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_n = 1'b1;
    logic         rdconv = 1'b1;
    logic         ext_mode = 1'b0;
    logic         ext_sclk = 1'b0;
    logic         tag_in = 1'b0;
    logic [W-1:0] sample_val = '0;
    logic         busy;
    logic         sclk_out;
    logic         sdo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int       rises = 0;
    int       edge_viol = 0;
    int       busy_low = 0;
    logic [W-1:0] cap = '0;
    logic     prev_sclk = 1'b0;
    logic     prev_sdo = 1'b0;

    always #2 clk = ~clk;

    adc_serial_port #(
        .RES_W      (W),
        .CONV_CYCLES(CONV),
        .LOAD_AT    (LOAD),
        .SCLK_QTR   (2),
        .SYNC_STAGES(2)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sel_n     (sel_n),
        .rdconv    (rdconv),
        .ext_mode  (ext_mode),
        .ext_sclk  (ext_sclk),
        .tag_in    (tag_in),
        .sample_val(sample_val),
        .busy      (busy),
        .sclk_out  (sclk_out),
        .sdo       (sdo)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk_out !== prev_sclk && sdo !== prev_sdo) edge_viol++;
            if (sclk_out === 1'b1 && prev_sclk === 1'b0) begin
                rises++;
                cap = {cap[W-2:0], sdo};
            end
            if (busy === 1'b0) busy_low++;
        end
        prev_sclk = sclk_out;
        prev_sdo  = sdo;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_busy_high();
        while (busy !== 1'b1) @(negedge clk);
    endtask

    task automatic run_internal(input logic [W-1:0] samp, input logic tg,
                                input logic [W-1:0] exp_prev, input bit retrig,
                                input string req);
        int r0, v0, b0;
        @(negedge clk);
        sample_val = samp;
        tag_in     = tg;
        r0 = rises; v0 = edge_viol; b0 = busy_low;
        sel_n  = 1'b0;
        rdconv = 1'b0;
        @(negedge clk);
        rdconv = 1'b1;
        chk("R1", "busy low after start", int'(busy), 0);
        repeat (30) @(negedge clk);
        tag_in = ~tg;
        if (retrig) begin
            rdconv = 1'b0;
            @(negedge clk);
            rdconv = 1'b1;
        end
        wait_busy_high();
        sel_n = 1'b1;
        chk("R1", "busy low span", busy_low - b0, CONV);
        chk("R2", "pulse count", rises - r0, W);
        chk(req, "burst data previous result", int'(cap), int'(exp_prev));
        chk("R4", "sdo moves at sclk edge", edge_viol - v0, 0);
        chk("R5", "tag after burst", int'(sdo), int'(tg));
        chk("R5", "sclk idle low", int'(sclk_out), 0);
        chk("R10", "sdo driven", int'(sdo === 1'b0 || sdo === 1'b1), 1);
    endtask

    task automatic ext_pulse(input logic tg);
        tag_in   = tg;
        ext_sclk = 1'b1;
        repeat (6) @(negedge clk);
        ext_sclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic ext_convert(input logic [W-1:0] samp, input logic hold_high);
        @(negedge clk);
        sel_n      = 1'b1;
        rdconv     = 1'b1;
        sample_val = samp;
        ext_sclk   = hold_high;
        repeat (6) @(negedge clk);
        sel_n  = 1'b0;
        rdconv = 1'b0;
        @(negedge clk);
        rdconv = 1'b1;
        wait_busy_high();
        repeat (2) @(negedge clk);
        sel_n    = 1'b1;
        ext_sclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R9", "busy after reset", int'(busy), 1);
        chk("R9", "sclk after reset", int'(sclk_out), 0);
        chk("R9", "sdo after reset", int'(sdo), 0);
    endtask

    task automatic test_ext_readout();
        int r0;
        logic [W-1:0] bits;
        ext_mode = 1'b1;
        r0 = rises;
        ext_convert(12'h9B6, 1'b0);
        chk("R6", "no internal pulses", rises - r0, 0);
        chk("R6", "new MSB on sdo", int'(sdo), 1);
        sel_n  = 1'b0;
        rdconv = 1'b1;
        bits = '0;
        for (int i = 0; i < W; i++) begin
            bits = {bits[W-2:0], sdo};
            ext_pulse(i == 0);
        end
        chk("R7", "external shifted word", int'(bits), 12'h9B6);
        chk("R7", "first tag after 12 edges", int'(sdo), 1);
        ext_pulse(1'b0);
        chk("R7", "second tag follows", int'(sdo), 0);
        sel_n = 1'b1;
    endtask

    task automatic test_ext_gate();
        ext_convert(12'h6D4, 1'b0);
        chk("R6", "MSB of new word", int'(sdo), 0);
        ext_pulse(1'b0);
        ext_pulse(1'b0);
        chk("R7", "no shift while deselected", int'(sdo), 0);
        sel_n  = 1'b0;
        rdconv = 1'b1;
        ext_pulse(1'b0);
        chk("R7", "shift once window open", int'(sdo), 1);
        sel_n = 1'b1;
    endtask

    task automatic test_hazard();
        ext_convert(12'h1E3, 1'b1);
        chk("R8", "sdo kept on lost load", int'(sdo), 1);
        ext_mode = 1'b0;
        run_internal(12'h0F0, 1'b0, 12'h6D4, 1'b0, "R8");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_internal(12'hA5C, 1'b1, 12'h000, 1'b0, "R3");
        run_internal(12'h3C7, 1'b0, 12'hA5C, 1'b0, "R3");
        run_internal(12'h5F1, 1'b1, 12'h3C7, 1'b1, "R3");
        test_ext_readout();
        test_ext_gate();
        test_hazard();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule